// File: doc/BRIEF.md
# SDRAM Self-Refresh Entry and Exit Sequencer

This block steers an SDR SDRAM controller into and out of self-refresh. Software writes one configuration byte that holds a low-power request bit, a select bit that picks self-refresh (0) or power-down (1), a clock-stop permission bit and an exit delay. When self-refresh is requested, the sequencer closes the front door to the command scheduler and waits until no access is outstanding. It then issues every refresh that is still owed and a precharge-all. After the row-precharge time it issues the self-refresh entry command. If clock stopping is permitted, it then turns off the memory clock enable.

Exit starts when software clears the low-power bit, or when the scheduler presents a request while the block sleeps. In both cases the clock comes back first and the exit command follows. The scheduler is held off for a programmable number of cycles before its handshake opens again. A waking request also clears the low-power bit in hardware, so that the block does not fall straight back asleep.

A synchronous domain reset behaves as a disable. While it is high no request is accepted and no request can wake the block. The configuration is left untouched and so is the sequencer's position.

Top module: `sdram_lp_seq`

## Requirements
- R1: Configuration byte layout: bit 0 low-power request, bit 1 select (0 = self-refresh), bit 2 clock-stop permission, bits 7:3 exit delay. A write that sets bit 0 with bit 1 clear makes the status read draining (code 1) two rising edges after the write cycle.
- R2: While acc_pending is high in the draining phase, no command other than NOP is issued. After it falls, one refresh command (code 2) is issued per unit of ref_debt. Consecutive refreshes are exactly T_RFC+2 cycles apart.
- R3: A precharge-all (code 1) follows the last refresh by exactly T_RFC+2 cycles. The entry command (code 3) follows the precharge-all by exactly T_RP+1 cycles, and the status reads self-refresh (code 2) from the next cycle on.
- R4: The clock enable falls only out of self-refresh, and only when bit 2 is set. It then stays low with status clock-stopped (code 3) and NOP on the command bus. With bit 2 clear, the clock keeps running in self-refresh.
- R5: Clearing bit 0 wakes the block. The exit command (code 4) is issued with the clock running. From clock-stopped, the clock enable rises exactly one cycle before the exit command.
- R6: req_ready rises exactly exit-delay+2 cycles after the exit command. Status reads exiting (code 4) in between.
- R7: A request (req_valid high, dom_rst low) that arrives in self-refresh or clock-stopped wakes the block and clears bit 0. The block then stays in normal after the request is served.
- R8: req_ready is high only in normal state with no self-refresh request pending and dom_rst low.
- R9: While dom_rst is high, req_ready is low and requests do not wake the block. The configuration survives, so a clock-stopped block is still clock-stopped after dom_rst falls.
- R10: Writing bit 0 set with bit 1 set (power-down select) starts no sequence. The status stays normal, req_ready stays high and no command is issued.
- R11: Status codes: 0 normal, 1 draining, 2 self-refresh, 3 clock-stopped, 4 exiting. No other value appears.
- R12: After rst_n the status is normal, the command is NOP, the clock enable is high and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears everything |
| dom_rst | input | 1 | Synchronous domain reset; blocks requests, keeps configuration |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration byte (layout in R1) |
| req_valid | input | 1 | Scheduler request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| acc_pending | input | 1 | High while any memory access is still outstanding |
| ref_debt | input | DEBT_W | Number of refreshes still owed; the owner decrements it on each refresh command |
| sd_cmd | output | 3 | SDRAM command: 0 NOP, 1 precharge-all, 2 refresh, 3 self-refresh entry, 4 self-refresh exit |
| mclk_en | output | 1 | Memory clock enable |
| lp_status | output | 3 | Sequencer status (codes in R11) |

## Verification
The request port follows valid/ready rules. A request may be held valid for any time and is taken only on an edge where req_ready is high, so a scheduler simply keeps its request up through a sleep. Every result is timed from the command it follows. The status moves to draining two edges after the configuration write. Refreshes are T_RFC+2 cycles apart, and entry comes T_RP+1 cycles after the precharge-all. In clock-stopped, the clock enable returns one cycle before the exit command, and req_ready rises exit-delay+2 cycles after it. A monitor stamps each command and each output edge with a cycle number at the falling clock edge. The checks compare the differences between these stamps with the expected gaps, so they do not depend on the absolute cycle in which a wait loop happens to end.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

  localparam int XDLY_W = 5;
  localparam int CFG_W  = XDLY_W + 3;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_REF  = 3'd2,
    CMD_SRE  = 3'd3,
    CMD_SRX  = 3'd4
  } sd_cmd_e;

  typedef enum logic [2:0] {
    LPS_NORMAL  = 3'd0,
    LPS_DRAIN   = 3'd1,
    LPS_SELFREF = 3'd2,
    LPS_CLKSTOP = 3'd3,
    LPS_EXIT    = 3'd4
  } lp_stat_e;

  typedef enum logic [3:0] {
    Q_IDLE, Q_DRAIN, Q_REF, Q_REF_W, Q_PRE, Q_PRE_W,
    Q_SRE, Q_SR, Q_CKOFF, Q_CKON, Q_SRX, Q_XWAIT
  } seq_e;

  typedef struct packed {
    logic [XDLY_W-1:0] xdly;
    logic              ck_stop;
    logic              pd_sel;
    logic              lp_mode;
  } lp_cfg_t;

endpackage

// File: rtl/sdram_lp_cfg.sv
module sdram_lp_cfg
  import sdram_lp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             hw_clr_lp,
  output lp_cfg_t          cfg
);

  // Only rst_n clears the configuration; the domain reset never reaches it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg <= lp_cfg_t'(wr_data);
    end else if (hw_clr_lp) begin
      cfg.lp_mode <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_lp_timer.sv
module sdram_lp_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sdram_lp_fsm.sv
module sdram_lp_fsm
  import sdram_lp_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_RFC = 8,
  parameter int TW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dom_rst,
  input  lp_cfg_t       cfg,
  input  logic          req_valid,
  input  logic          acc_pending,
  input  logic          debt_nz,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          clr_lp,
  output sd_cmd_e       cmd,
  output lp_stat_e      status,
  output logic          mclk_en,
  output logic          req_ready
);

  seq_e state, state_nx;
  logic lp_act;
  logic wake_req;
  logic wake;

  assign lp_act   = cfg.lp_mode & ~cfg.pd_sel;
  assign wake_req = req_valid & ~dom_rst;
  assign wake     = wake_req | ~lp_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= Q_IDLE;
    else        state <= state_nx;
  end

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    clr_lp   = 1'b0;
    unique case (state)
      Q_IDLE:  if (lp_act) state_nx = Q_DRAIN;
      Q_DRAIN: if (!acc_pending) state_nx = debt_nz ? Q_REF : Q_PRE;
      Q_REF: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(T_RFC - 1);
        state_nx = Q_REF_W;
      end
      Q_REF_W: if (tmr_zero) state_nx = Q_DRAIN;
      Q_PRE: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(T_RP - 1);
        state_nx = Q_PRE_W;
      end
      Q_PRE_W: if (tmr_zero) state_nx = Q_SRE;
      Q_SRE:   state_nx = Q_SR;
      Q_SR: begin
        if (wake) begin
          clr_lp   = wake_req;
          state_nx = Q_SRX;
        end else if (cfg.ck_stop) begin
          state_nx = Q_CKOFF;
        end
      end
      Q_CKOFF: begin
        if (wake) begin
          clr_lp   = wake_req;
          state_nx = Q_CKON;
        end
      end
      Q_CKON: state_nx = Q_SRX;
      Q_SRX: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(cfg.xdly);
        state_nx = Q_XWAIT;
      end
      Q_XWAIT: if (tmr_zero) state_nx = Q_IDLE;
      default: state_nx = Q_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      Q_REF:   cmd = CMD_REF;
      Q_PRE:   cmd = CMD_PREA;
      Q_SRE:   cmd = CMD_SRE;
      Q_SRX:   cmd = CMD_SRX;
      default: cmd = CMD_NOP;
    endcase
  end

  always_comb begin
    unique case (state)
      Q_IDLE:                         status = LPS_NORMAL;
      Q_SR:                           status = LPS_SELFREF;
      Q_CKOFF:                        status = LPS_CLKSTOP;
      Q_CKON, Q_SRX, Q_XWAIT:         status = LPS_EXIT;
      default:                        status = LPS_DRAIN;
    endcase
  end

  assign mclk_en   = (state != Q_CKOFF);
  assign req_ready = (state == Q_IDLE) & ~lp_act & ~dom_rst;

endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
  import sdram_lp_pkg::*;
#(
  parameter int T_RP   = 3,
  parameter int T_RFC  = 8,
  parameter int DEBT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dom_rst,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              acc_pending,
  input  logic [DEBT_W-1:0] ref_debt,
  output logic [2:0]        sd_cmd,
  output logic              mclk_en,
  output logic [2:0]        lp_status
);

  localparam int XMAX  = (1 << XDLY_W) - 1;
  localparam int TMAX0 = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int TMAX  = (TMAX0 > XMAX) ? TMAX0 : XMAX;
  localparam int TW    = $clog2(TMAX + 1);

  lp_cfg_t       cfg;
  logic          clr_lp;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  sd_cmd_e       cmd;
  lp_stat_e      status;

  sdram_lp_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_data   (cfg_wr_data),
    .hw_clr_lp (clr_lp),
    .cfg       (cfg)
  );

  sdram_lp_timer #(.W(TW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .val   (tmr_val),
    .zero  (tmr_zero)
  );

  sdram_lp_fsm #(.T_RP(T_RP), .T_RFC(T_RFC), .TW(TW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .dom_rst     (dom_rst),
    .cfg         (cfg),
    .req_valid   (req_valid),
    .acc_pending (acc_pending),
    .debt_nz     (|ref_debt),
    .tmr_zero    (tmr_zero),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .clr_lp      (clr_lp),
    .cmd         (cmd),
    .status      (status),
    .mclk_en     (mclk_en),
    .req_ready   (req_ready)
  );

  assign sd_cmd    = cmd;
  assign lp_status = status;

endmodule

// File: rtl/sdram_lp_chk.sv
module sdram_lp_chk
  import sdram_lp_pkg::*;
#(
  parameter int DEBT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dom_rst,
  input logic              req_ready,
  input logic              acc_pending,
  input logic [DEBT_W-1:0] ref_debt,
  input logic [2:0]        sd_cmd,
  input logic              mclk_en,
  input logic [2:0]        lp_status
);

  AST_SRE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_SRE) |-> (!acc_pending && ref_debt == '0)); // R2

  AST_SR_AFTER_SRE: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_status == LPS_SELFREF && $past(lp_status) == LPS_DRAIN) |-> ($past(sd_cmd) == CMD_SRE)); // R3

  AST_CLK_STOP_FROM_SR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mclk_en) |-> ($past(lp_status) == LPS_SELFREF)); // R4

  AST_QUIET_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_en |-> (sd_cmd == CMD_NOP)); // R4

  AST_SRX_CLK_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_SRX) |-> (mclk_en && $past(mclk_en))); // R5

  AST_READY_NORMAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (lp_status == LPS_NORMAL)); // R8

  AST_NO_READY_DOMRST: assert property (@(posedge clk) disable iff (!rst_n)
    dom_rst |-> !req_ready); // R9

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    lp_status <= 3'd4); // R11

endmodule

bind sdram_lp_seq sdram_lp_chk #(.DEBT_W(DEBT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dom_rst     (dom_rst),
  .req_ready   (req_ready),
  .acc_pending (acc_pending),
  .ref_debt    (ref_debt),
  .sd_cmd      (sd_cmd),
  .mclk_en     (mclk_en),
  .lp_status   (lp_status)
);

// File: tb/sdram_lp_seq_tb.sv
module sdram_lp_seq_tb;

  localparam int T_RP   = 3;
  localparam int T_RFC  = 8;
  localparam int DEBT_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              dom_rst = 1'b0;
  logic              cfg_wr_en = 1'b0;
  logic [7:0]        cfg_wr_data = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              acc_pending = 1'b0;
  logic [DEBT_W-1:0] ref_debt;
  logic [2:0]        sd_cmd;
  logic              mclk_en;
  logic [2:0]        lp_status;

  int checks = 0;
  int fails  = 0;
  int cyc = 0;

  // Monitor state (written only by the monitor)
  int ref_total = 0, gap_err = 0;
  int t_last_ref = -1000, t_pre = -1000, t_sre = -1000, t_srx = -1000;
  int t_rdy = -1000, t_ckon = -1000, n_cmd = 0;
  logic prev_rdy = 1'b1, prev_ck = 1'b1;

  // Refresh owner model
  int debt_target = 0;
  assign ref_debt = (debt_target > ref_total) ? DEBT_W'(debt_target - ref_total) : '0;

  sdram_lp_seq #(.T_RP(T_RP), .T_RFC(T_RFC), .DEBT_W(DEBT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .dom_rst(dom_rst), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_data(cfg_wr_data), .req_valid(req_valid), .req_ready(req_ready),
    .acc_pending(acc_pending), .ref_debt(ref_debt), .sd_cmd(sd_cmd),
    .mclk_en(mclk_en), .lp_status(lp_status)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sd_cmd != 3'd0) n_cmd = n_cmd + 1;
    case (sd_cmd)
      3'd2: begin
        if (t_last_ref > t_pre && cyc - t_last_ref != T_RFC + 2) gap_err = gap_err + 1;
        t_last_ref = cyc;
        ref_total  = ref_total + 1;
      end
      3'd1: t_pre = cyc;
      3'd3: t_sre = cyc;
      3'd4: t_srx = cyc;
      default: ;
    endcase
    if (req_ready && !prev_rdy) t_rdy = cyc;
    if (mclk_en && !prev_ck) t_ckon = cyc;
    prev_rdy = req_ready;
    prev_ck  = mclk_en;
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wr_cfg(logic [7:0] d);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = d;
    step();
    cfg_wr_en   = 1'b0;
  endtask

  task automatic wait_status(logic [2:0] s, string tag);
    int n = 0;
    while (lp_status != s && n < 500) begin
      step();
      n++;
    end
    chk(lp_status == s, tag, int'(lp_status), int'(s));
  endtask

  task automatic wait_ready(string tag);
    int n = 0;
    while (!req_ready && n < 500) begin
      step();
      n++;
    end
    chk(req_ready == 1'b1, tag, int'(req_ready), 1);
  endtask

  task automatic run(int debt, int ck, int wake, int xdly);
    int ref0, err0, cmd0;
    logic [2:0] sleep_st;
    sleep_st = (ck != 0) ? 3'd3 : 3'd2;
    ref0 = ref_total;
    err0 = gap_err;
    debt_target = ref_total + debt;
    acc_pending = 1'b1;
    step();
    cmd0 = n_cmd;
    wr_cfg({5'(xdly), 1'(ck), 1'b0, 1'b1});
    step();
    // R1: draining two edges after the write; R8: handshake closed
    chk(lp_status == 3'd1, "R1 draining status", int'(lp_status), 1);
    chk(req_ready == 1'b0, "R8 ready low while draining", int'(req_ready), 0);
    step(4);
    // R2: nothing issued while accesses are outstanding
    chk(n_cmd == cmd0, "R2 no command while acc_pending", n_cmd - cmd0, 0);
    acc_pending = 1'b0;
    wait_status(sleep_st, "R3 reached sleep state");
    step(3);
    chk(ref_total - ref0 == debt, "R2 refresh count", ref_total - ref0, debt);
    chk(gap_err == err0, "R2 refresh spacing", gap_err - err0, 0);
    if (debt > 0)
      chk(t_pre - t_last_ref == T_RFC + 2, "R3 precharge after last refresh",
          t_pre - t_last_ref, T_RFC + 2);
    chk(t_sre - t_pre == T_RP + 1, "R3 entry after precharge", t_sre - t_pre, T_RP + 1);
    chk(lp_status == sleep_st, "R4 sleep status held", int'(lp_status), int'(sleep_st));
    chk(mclk_en == (ck == 0), "R4 clock enable in sleep", int'(mclk_en), int'(ck == 0));
    if (wake != 0) req_valid = 1'b1;
    else           wr_cfg({5'(xdly), 1'(ck), 1'b0, 1'b0});
    wait_ready("R6 ready returns");
    step();
    req_valid = 1'b0;
    step();
    chk(t_rdy - t_srx == xdly + 2, "R6 exit delay", t_rdy - t_srx, xdly + 2);
    if (ck != 0)
      chk(t_srx - t_ckon == 1, "R5 clock back before exit command", t_srx - t_ckon, 1);
    step(3);
    chk(lp_status == 3'd0, "R7 stays normal after wake", int'(lp_status), 0);
    chk(req_ready == 1'b1, "R7 ready after wake", int'(req_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R12 reset state
    chk(lp_status == 3'd0, "R12 status normal", int'(lp_status), 0);
    chk(sd_cmd == 3'd0, "R12 command NOP", int'(sd_cmd), 0);
    chk(mclk_en == 1'b1, "R12 clock enabled", int'(mclk_en), 1);
    chk(req_ready == 1'b1, "R12 ready high", int'(req_ready), 1);

    // R10 power-down select starts nothing
    begin
      int c0;
      c0 = n_cmd;
      wr_cfg(8'b0000_0111);
      step(6);
      chk(lp_status == 3'd0, "R10 status stays normal", int'(lp_status), 0);
      chk(req_ready == 1'b1, "R10 ready stays high", int'(req_ready), 1);
      chk(n_cmd == c0, "R10 no command", n_cmd - c0, 0);
      wr_cfg(8'h00);
      step();
    end

    // Sweep refresh debt, clock-stop permission and wake source (R1-R8)
    for (int d = 0; d < 4; d++)
      for (int k = 0; k < 2; k++)
        for (int w = 0; w < 2; w++)
          run(d, k, w, d * 5 + k * 3 + w);

    // R9 domain reset
    dom_rst = 1'b1;
    step();
    chk(req_ready == 1'b0, "R9 ready low in domain reset", int'(req_ready), 0);
    dom_rst = 1'b0;
    step();
    chk(req_ready == 1'b1, "R9 ready back after domain reset", int'(req_ready), 1);
    debt_target = ref_total;
    wr_cfg(8'b0001_0101);
    wait_status(3'd3, "R9 clock-stopped before domain reset");
    dom_rst   = 1'b1;
    req_valid = 1'b1;
    step(6);
    chk(lp_status == 3'd3, "R9 request ignored in domain reset", int'(lp_status), 3);
    chk(mclk_en == 1'b0, "R9 clock stays off in domain reset", int'(mclk_en), 0);
    chk(req_ready == 1'b0, "R9 ready low in domain reset", int'(req_ready), 0);
    req_valid = 1'b0;
    step();
    dom_rst = 1'b0;
    step(4);
    chk(lp_status == 3'd3, "R9 configuration kept", int'(lp_status), 3);
    req_valid = 1'b1;
    wait_ready("R9 wake after domain reset");
    step();
    req_valid = 1'b0;
    step(2);
    chk(t_rdy - t_srx == 2 + 2, "R6 exit delay after domain reset", t_rdy - t_srx, 4);
    chk(lp_status == 3'd0, "R11 normal code", int'(lp_status), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule